// File: doc/BRIEF.md
# Debounced Push-On/Push-Off Switch

This block turns a momentary push button into a latched on/off level. Each accepted press flips the output. Releases are tracked as separate states, so holding the button down never causes a second flip. Contact bounce is filtered by a hold-off counter that runs on a slow tick strobe. The counter blocks all state evaluation for a fixed number of ticks after every accepted edge, and also after reset.

The raw button level first passes through a two-flop synchronizer. A one-cycle strobe from an external millisecond timebase paces the state machine, which does nothing between strobes. The latched level drives both the switch output and an LED output.

Top module: `push_toggle_switch`

## Requirements
- R1: After reset `sw_o` is 0 and the hold-off counter is full, so a held press is ignored for the first `HOLD_TICKS` ticks and accepted on the tick after them.
- R2: `btn_i` passes through two flops before it is used. A tick on the first or second rising clock edge after a change still sees the old level, and a tick on the third edge sees the new level.
- R3: The state and `sw_o` change only on a clock edge where `tick_i` is 1. Any number of cycles without a tick leaves `sw_o` unchanged, even if the button is pressed.
- R4: While the hold-off counter is nonzero, each tick decrements it by one and no transition is evaluated.
- R5: Every state transition, releases included, reloads the counter to `HOLD_TICKS`. After a release is accepted, a press needs `HOLD_TICKS` ignored ticks before it counts.
- R6: In the off-and-released state, a pressed level on an evaluated tick sets `sw_o` to 1 and moves to the on-and-held state.
- R7: In the on-and-held state, a released level on an evaluated tick moves to the on-and-released state and leaves `sw_o` at 1.
- R8: In the on-and-released state, a pressed level on an evaluated tick clears `sw_o` to 0 and moves to the off-and-held state.
- R9: In the off-and-held state, a released level on an evaluated tick returns to the off-and-released state with `sw_o` at 0. A later accepted press turns the output on again.
- R10: `led_o` always equals `sw_o`.
- R11: Bounce pulses that fall inside the hold-off window after an accepted edge cause no extra toggle.
- R12: A press held for many ticks after it has been accepted causes no further toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timebase strobe that paces evaluation |
| btn_i | input | 1 | Raw button level, 1 = pressed |
| sw_o | output | 1 | Latched switch level |
| led_o | output | 1 | LED drive, a copy of the switch level |

## Verification
A wrong state or a wrong counter value inside the block shows up at `sw_o` only when the next press or release is evaluated. That can be as late as `HOLD_TICKS + 1` ticks after the fault. An early or late count shifts the tick on which a held press flips the output. A confused press/release state shows up either as a flip on a release or as a second flip while the button is held. For this reason the bench checks the output after every tick, and it counts the exact tick on which each flip is expected.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    S_OFF_ARM   = 2'd0,  // off, released, waiting for press
    S_ON_LATCH  = 2'd1,  // on, held, waiting for release
    S_ON_ARM    = 2'd2,  // on, released, waiting for press
    S_OFF_LATCH = 2'd3   // off, held, waiting for release
  } sw_state_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
  parameter int HOLD_TICKS = 10,
  localparam int CNT_W = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  output logic idle_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_TICKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= RELOAD;
    else if (load_i)                cnt_q <= RELOAD;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);

  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == RELOAD);

  // R4
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/toggle_fsm.sv
module toggle_fsm
  import pt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic idle_i,
  input  logic btn_i,
  output logic move_o,
  output logic sw_o
);
  sw_state_e state_q, state_d;
  logic      sw_q, sw_d;

  always_comb begin
    state_d = state_q;
    sw_d    = sw_q;
    if (tick_i && idle_i) begin
      unique case (state_q)
        S_OFF_ARM:   if (btn_i)  begin state_d = S_ON_LATCH;  sw_d = 1'b1; end
        S_ON_LATCH:  if (!btn_i) state_d = S_ON_ARM;
        S_ON_ARM:    if (btn_i)  begin state_d = S_OFF_LATCH; sw_d = 1'b0; end
        S_OFF_LATCH: if (!btn_i) state_d = S_OFF_ARM;
        default:     state_d = S_OFF_ARM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OFF_ARM;
      sw_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sw_q    <= sw_d;
    end
  end

  assign move_o = (state_d != state_q);
  assign sw_o   = sw_q;

  // R3
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q) && $stable(sw_q));

  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !idle_i) |=> $stable(state_q));

  // R7
  release_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ON_LATCH) |=> sw_q);

  // R6
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_q) |-> $past(state_q) == S_OFF_ARM);

  // R8
  fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_q) |-> $past(state_q) == S_ON_ARM);
endmodule

// File: rtl/push_toggle_switch.sv
module push_toggle_switch #(
  parameter int HOLD_TICKS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_i,
  output logic sw_o,
  output logic led_o
);
  logic btn_s, idle, move, sw;

  btn_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_i),
    .q_o   (btn_s)
  );

  holdoff_timer #(.HOLD_TICKS(HOLD_TICKS)) i_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .load_i(move),
    .idle_o(idle)
  );

  toggle_fsm i_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .idle_i(idle),
    .btn_i (btn_s),
    .move_o(move),
    .sw_o  (sw)
  );

  assign sw_o  = sw;
  assign led_o = sw;
endmodule

// File: tb/test_push_toggle_switch.sv
module test_push_toggle_switch;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic btn_i = 1'b0;
  logic sw_o, led_o;

  int vectors = 0;
  int miscompares = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  push_toggle_switch #(.HOLD_TICKS(HOLD)) i_push_toggle_switch (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .btn_i (btn_i),
    .sw_o  (sw_o),
    .led_o (led_o)
  );

  // monitor: pops expectations a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (sw_o !== e) begin
          miscompares++;
          $display("FAIL %s: sw_o=%0b expected %0b", t, sw_o, e);
        end
        vectors++;
        if (led_o !== sw_o) begin
          miscompares++;
          $display("FAIL R10: led_o=%0b expected %0b", led_o, sw_o);
        end
      end
    end
  end

  task automatic expect_sw(input bit e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic tick_with(input logic b, input bit e, input string t);
    @(negedge clk);
    btn_i = b;
    repeat (3) @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    expect_sw(e, t);
  endtask

  task automatic ticks(input int n, input logic b, input bit e, input string t);
    for (int i = 0; i < n; i++) tick_with(b, e, t);
  endtask

  task automatic bounce(input int n, input bit e, input string t);
    for (int i = 0; i < n; i++) tick_with(logic'(i % 2 == 0), e, t);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: done=0 expected 1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_sw(1'b0, "R1 reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    ticks(HOLD, 1'b1, 1'b0, "R1 reset holdoff");
    tick_with(1'b1, 1'b1, "R6 press on");
    ticks(HOLD, 1'b1, 1'b1, "R12 held in holdoff");
    ticks(3, 1'b1, 1'b1, "R12 held after holdoff");
    tick_with(1'b0, 1'b1, "R7 release keeps on");
    ticks(HOLD, 1'b1, 1'b1, "R5 reload after release");
    tick_with(1'b1, 1'b0, "R8 press off");
    ticks(HOLD, 1'b0, 1'b0, "R4 release in holdoff");
    tick_with(1'b0, 1'b0, "R9 release back to armed");
    bounce(HOLD, 1'b0, "R11 bounce after release");

    @(negedge clk);
    btn_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      expect_sw(1'b0, "R3 no tick");
    end
    tick_with(1'b1, 1'b1, "R9 press on again");
    bounce(HOLD, 1'b1, "R11 bounce after press");
    tick_with(1'b0, 1'b1, "R7 release");
    ticks(HOLD, 1'b0, 1'b1, "R4 idle holdoff");

    // R2: tick on the second edge after the change sees the old level
    @(negedge clk);
    btn_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    expect_sw(1'b1, "R2 second edge");
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    expect_sw(1'b0, "R2 third edge");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule